// File: doc/BRIEF.md
# ATA Host PIO Cycle Timer

This block runs single programmed-I/O data cycles from the host side of an ATA bus. An upstream agent hands it one request at a time. A request carries the chip-select pair, the three device address bits, the direction and, for a write, a 16-bit word. The block then sequences the bus. First it drives the address, and it holds the address by itself for a setup interval. Next it pulls the selected strobe low for the active interval. Last it lets the strobe recover before the cycle ends. It reports completion with a one-clock pulse, and a read returns its data word with that pulse.

A small configuration register holds the transfer mode (0 to 4) and an IORDY wait limit. Each interval is derived at elaboration from nanosecond minimums and the clock period. Every value is rounded up to whole clocks, so no minimum is ever violated. In the two fastest modes the device may hold IORDY low to stretch the strobe. If IORDY stays low past the programmed limit, the cycle is abandoned and flagged. The slower modes never look at IORDY.

Top module: `ata_pio_engine`

## Requirements
- R1: While reset is asserted, both strobes are high, `ata_cs_n` is 2'b11, `ata_da` is 0, `ata_dd_oe` is 0 and `done` and `err` are 0. After reset `req_ready` is 1 and the mode is 0.
- R2: After a request is accepted, `ata_cs_n`/`ata_da` show the requested values with both strobes high for exactly S = ceil(tsetup/Tclk) clocks. They stay unchanged until the cycle ends and return to 2'b11/0 when `done` rises. The tsetup values are 70, 50, 30, 30 and 25 ns for modes 0 to 4.
- R3: With IORDY high, the strobe stays low for exactly A = ceil(tactive/Tclk) clocks. The tactive values are 165, 125, 100, 80 and 70 ns for modes 0 to 4. A read lowers only `ata_dior_n` and a write lowers only `ata_diow_n`.
- R4: Recovery lasts R = max(1, T - S - A) clocks, where T = ceil(tcycle/Tclk). The tcycle values are 600, 383, 240, 180 and 120 ns for modes 0 to 4. Setup, active and recovery therefore total at least T clocks.
- R5: On a write, `ata_dd_oe` is 1 and `ata_dd_out` holds the request word from address-valid through the last recovery clock. This is at least one clock after `ata_diow_n` rises. On a read, `ata_dd_oe` stays 0.
- R6: A read captures `ata_dd_in` at the clock edge where `ata_dior_n` rises and presents it on `rdata` with `done`. `rdata` keeps that value until the next read completes, and a write leaves it unchanged.
- R7: `done` is high for exactly one clock, in the first clock after recovery. `req_ready` is 1 only while no cycle is in progress, including the `done` clock.
- R8: In modes 0 to 2, IORDY low has no effect: the strobe width stays A and `err` stays 0.
- R9: In modes 3 and 4, IORDY low at the end of the active interval extends the strobe. IORDY is resynchronised through two flops. The cycle completes normally after IORDY returns high, with a width greater than A and at most A + L, where L is the wait limit.
- R10: In modes 3 and 4, if IORDY is still low after L extra strobe clocks, the strobe is low for exactly A + L clocks. The cycle then recovers normally, and `err` is 1 in the same clock as `done`.
- R11: A mode value written above 4 acts as mode 4. Writes to the configuration take effect from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load mode and wait limit |
| cfg_mode | input | 3 | PIO mode to load (values above 4 act as 4) |
| cfg_wait_limit | input | WLW | Maximum IORDY extension in clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted on this clock |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_cs_n | input | 2 | Chip-select pair to drive (active low) |
| req_da | input | 3 | Device address bits |
| req_wdata | input | DW | Write data word |
| done | output | 1 | One-clock cycle completion |
| err | output | 1 | IORDY timeout, valid with done |
| rdata | output | DW | Captured read word |
| ata_cs_n | output | 2 | Bus chip selects |
| ata_da | output | 3 | Bus device address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | DW | Data driven toward the device |
| ata_dd_oe | output | 1 | Data output enable |
| ata_dd_in | input | DW | Data from the device |
| ata_iordy | input | 1 | Device ready, low stretches strobe |

## Verification
Every mode is swept in both directions with IORDY high, and each interval is measured against its arithmetic clock count. This shows whether the per-mode tables are selected and rounded correctly. It also separates a wrong setup count from a wrong active or recovery count. Holding IORDY low in a slow mode versus a fast mode shows whether the extension is gated by mode. In a fast mode, releasing IORDY partway through is run against never releasing it. This separates a normal stretched completion from a timeout abort with its exact A + L width. The bench changes the read bus value just after the strobe rises and writes an out-of-range mode. These two patterns expose a late capture edge and a missing mode clamp.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int NUM_MODES = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_RECOV
  } pio_state_e;

  // Round a nanosecond minimum up to whole clocks of clk_ps picoseconds.
  function automatic int ns_to_clks(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int cycle_ns(input int m);
    case (m)
      0:       return 600;
      1:       return 383;
      2:       return 240;
      3:       return 180;
      default: return 120;
    endcase
  endfunction

  function automatic int setup_ns(input int m);
    case (m)
      0:       return 70;
      1:       return 50;
      2:       return 30;
      3:       return 30;
      default: return 25;
    endcase
  endfunction

  function automatic int active_ns(input int m);
    case (m)
      0:       return 165;
      1:       return 125;
      2:       return 100;
      3:       return 80;
      default: return 70;
    endcase
  endfunction

endpackage

// File: rtl/ata_pio_cfg.sv
module ata_pio_cfg #(
  parameter int WLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [2:0]     cfg_mode,
  input  logic [WLW-1:0] cfg_wait_limit,
  output logic [2:0]     mode,
  output logic [WLW-1:0] wait_limit
);

  logic [2:0]     mode_q, mode_d;
  logic [WLW-1:0] limit_q, limit_d;

  always_comb begin
    mode_d  = mode_q;
    limit_d = limit_q;
    if (cfg_wr) begin
      mode_d  = (cfg_mode > 3'd4) ? 3'd4 : cfg_mode;
      limit_d = cfg_wait_limit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 3'd0;
      limit_q <= '1;
    end else if (cfg_wr) begin
      mode_q  <= mode_d;
      limit_q <= limit_d;
    end
  end

  assign mode       = mode_q;
  assign wait_limit = limit_q;

  // R11: the stored mode never leaves the supported range
  p_mode_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q <= 3'd4);

endmodule

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
  import ata_pio_pkg::*;
#(
  parameter int CLK_PS = 4000,
  parameter int CW     = 8
) (
  input  logic [2:0]    mode,
  output logic [CW-1:0] setup_clks,
  output logic [CW-1:0] active_clks,
  output logic [CW-1:0] recov_clks,
  output logic          iordy_en
);

  logic [CW-1:0] s_tab [NUM_MODES];
  logic [CW-1:0] a_tab [NUM_MODES];
  logic [CW-1:0] r_tab [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int S  = ns_to_clks(setup_ns(m), CLK_PS);
    localparam int A  = ns_to_clks(active_ns(m), CLK_PS);
    localparam int T  = ns_to_clks(cycle_ns(m), CLK_PS);
    localparam int RR = T - S - A;
    localparam int R  = (RR > 1) ? RR : 1;
    assign s_tab[m] = CW'(S);
    assign a_tab[m] = CW'(A);
    assign r_tab[m] = CW'(R);
  end

  logic [2:0] sel;

  always_comb begin
    sel         = (mode < 3'(NUM_MODES)) ? mode : 3'(NUM_MODES - 1);
    setup_clks  = s_tab[sel];
    active_clks = a_tab[sel];
    recov_clks  = r_tab[sel];
    iordy_en    = (sel >= 3'd3);
  end

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int CW  = 8,
  parameter int WLW = 8,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [1:0]     req_cs_n,
  input  logic [2:0]     req_da,
  input  logic [DW-1:0]  req_wdata,
  output logic           req_ready,
  input  logic [CW-1:0]  setup_clks,
  input  logic [CW-1:0]  active_clks,
  input  logic [CW-1:0]  recov_clks,
  input  logic           iordy_en,
  input  logic [WLW-1:0] wait_limit,
  input  logic           ata_iordy,
  input  logic [DW-1:0]  ata_dd_in,
  output logic [1:0]     ata_cs_n,
  output logic [2:0]     ata_da,
  output logic           ata_dior_n,
  output logic           ata_diow_n,
  output logic [DW-1:0]  ata_dd_out,
  output logic           ata_dd_oe,
  output logic [DW-1:0]  rdata,
  output logic           done,
  output logic           err
);

  pio_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d, act_q, act_d, rec_q, rec_d;
  logic [WLW-1:0] wcnt_q, wcnt_d, lim_q, lim_d;
  logic           ext_q, ext_d, wr_q, wr_d, abort_q, abort_d;
  logic [1:0]     cs_q, cs_d;
  logic [2:0]     da_q, da_d;
  logic [DW-1:0]  wdata_q, wdata_d, rdata_q, rdata_d;
  logic           done_q, done_d, err_q, err_d;
  logic           rdy_s1_q, rdy_s2_q;
  logic           leave;

  always_comb begin
    state_d = state_q;  cnt_d = cnt_q;  act_d = act_q;  rec_d = rec_q;
    wcnt_d  = wcnt_q;   lim_d = lim_q;  ext_d = ext_q;  wr_d  = wr_q;
    abort_d = abort_q;  cs_d  = cs_q;   da_d  = da_q;   wdata_d = wdata_q;
    rdata_d = rdata_q;  done_d = 1'b0;  err_d = 1'b0;   leave = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        state_d = ST_SETUP;
        cnt_d   = setup_clks - 1'b1;
        act_d   = active_clks;
        rec_d   = recov_clks;
        ext_d   = iordy_en;
        lim_d   = wait_limit;
        wr_d    = req_write;
        cs_d    = req_cs_n;
        da_d    = req_da;
        wdata_d = req_wdata;
        wcnt_d  = '0;
        abort_d = 1'b0;
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          state_d = ST_ACTIVE;
          cnt_d   = act_q - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (ext_q && !rdy_s2_q) begin
          if (wcnt_q == lim_q) begin
            abort_d = 1'b1;
            leave   = 1'b1;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end else begin
          leave = 1'b1;
        end
        if (leave) begin
          state_d = ST_RECOV;
          cnt_d   = rec_q - 1'b1;
          if (!wr_q) rdata_d = ata_dd_in;
        end
      end
      ST_RECOV: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = abort_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  cnt_q <= '0;  act_q <= '0;  rec_q <= '0;
      wcnt_q  <= '0;       lim_q <= '0;  ext_q <= 1'b0; wr_q <= 1'b0;
      abort_q <= 1'b0;     cs_q  <= 2'b11; da_q <= '0;  wdata_q <= '0;
      rdata_q <= '0;       done_q <= 1'b0; err_q <= 1'b0;
      rdy_s1_q <= 1'b1;    rdy_s2_q <= 1'b1;
    end else begin
      state_q <= state_d;  cnt_q <= cnt_d;  act_q <= act_d;  rec_q <= rec_d;
      wcnt_q  <= wcnt_d;   lim_q <= lim_d;  ext_q <= ext_d;  wr_q  <= wr_d;
      abort_q <= abort_d;  cs_q  <= cs_d;   da_q  <= da_d;   wdata_q <= wdata_d;
      rdata_q <= rdata_d;  done_q <= done_d; err_q <= err_d;
      rdy_s1_q <= ata_iordy;
      rdy_s2_q <= rdy_s1_q;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign ata_cs_n   = (state_q == ST_IDLE) ? 2'b11 : cs_q;
  assign ata_da     = (state_q == ST_IDLE) ? 3'd0 : da_q;
  assign ata_dior_n = !((state_q == ST_ACTIVE) && !wr_q);
  assign ata_diow_n = !((state_q == ST_ACTIVE) && wr_q);
  assign ata_dd_oe  = (state_q != ST_IDLE) && wr_q;
  assign ata_dd_out = wdata_q;
  assign rdata      = rdata_q;
  assign done       = done_q;
  assign err        = err_q;

  // R3: never both strobes low
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));
  // R2: address held for the whole cycle
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> ($stable(ata_cs_n) && $stable(ata_da)));
  // R5: write strobe only with data driven
  p_wdata_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_diow_n |-> ata_dd_oe);
  // R7: single-clock completion, engine idle at completion
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ready_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  // R10: error reported only alongside completion
  p_err_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R8: no wait clocks counted in a mode without IORDY
  p_no_wait_slow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt_q != '0) |-> ext_q);

endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int CLK_PS = 4000,
  parameter int WLW    = 8,
  parameter int DW     = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [2:0]     cfg_mode,
  input  logic [WLW-1:0] cfg_wait_limit,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [1:0]     req_cs_n,
  input  logic [2:0]     req_da,
  input  logic [DW-1:0]  req_wdata,
  output logic           done,
  output logic           err,
  output logic [DW-1:0]  rdata,
  output logic [1:0]     ata_cs_n,
  output logic [2:0]     ata_da,
  output logic           ata_dior_n,
  output logic           ata_diow_n,
  output logic [DW-1:0]  ata_dd_out,
  output logic           ata_dd_oe,
  input  logic [DW-1:0]  ata_dd_in,
  input  logic           ata_iordy
);

  localparam int CW = $clog2(ns_to_clks(cycle_ns(0), CLK_PS) + 1);

  logic           rst_meta_q, rst_sync_q;
  logic [2:0]     mode;
  logic [WLW-1:0] wait_limit;
  logic [CW-1:0]  setup_clks, active_clks, recov_clks;
  logic           iordy_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ata_pio_cfg #(.WLW(WLW)) u_cfg (
    .clk            (clk),
    .rst_n          (rst_sync_q),
    .cfg_wr         (cfg_wr),
    .cfg_mode       (cfg_mode),
    .cfg_wait_limit (cfg_wait_limit),
    .mode           (mode),
    .wait_limit     (wait_limit)
  );

  ata_pio_timing #(.CLK_PS(CLK_PS), .CW(CW)) u_timing (
    .mode        (mode),
    .setup_clks  (setup_clks),
    .active_clks (active_clks),
    .recov_clks  (recov_clks),
    .iordy_en    (iordy_en)
  );

  ata_pio_seq #(.CW(CW), .WLW(WLW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_cs_n    (req_cs_n),
    .req_da      (req_da),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .setup_clks  (setup_clks),
    .active_clks (active_clks),
    .recov_clks  (recov_clks),
    .iordy_en    (iordy_en),
    .wait_limit  (wait_limit),
    .ata_iordy   (ata_iordy),
    .ata_dd_in   (ata_dd_in),
    .ata_cs_n    (ata_cs_n),
    .ata_da      (ata_da),
    .ata_dior_n  (ata_dior_n),
    .ata_diow_n  (ata_diow_n),
    .ata_dd_out  (ata_dd_out),
    .ata_dd_oe   (ata_dd_oe),
    .rdata       (rdata),
    .done        (done),
    .err         (err)
  );

endmodule

// File: tb/tb_ata_pio_engine.sv
`timescale 1ns/1ps
module tb_ata_pio_engine;

  localparam int WLW = 8;
  localparam int DW  = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cfg_wr;
  logic [2:0]     cfg_mode;
  logic [WLW-1:0] cfg_wait_limit;
  logic           req_valid, req_ready, req_write;
  logic [1:0]     req_cs_n;
  logic [2:0]     req_da;
  logic [DW-1:0]  req_wdata;
  logic           done, err;
  logic [DW-1:0]  rdata;
  logic [1:0]     ata_cs_n;
  logic [2:0]     ata_da;
  logic           ata_dior_n, ata_diow_n, ata_dd_oe, ata_iordy;
  logic [DW-1:0]  ata_dd_out, ata_dd_in;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ata_pio_engine #(.CLK_PS(4000), .WLW(WLW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_wait_limit(cfg_wait_limit), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cs_n(req_cs_n), .req_da(req_da),
    .req_wdata(req_wdata), .done(done), .err(err), .rdata(rdata),
    .ata_cs_n(ata_cs_n), .ata_da(ata_da), .ata_dior_n(ata_dior_n),
    .ata_diow_n(ata_diow_n), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
    .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
  );

  function automatic int cdiv(input int ns);
    return (ns * 1000 + 3999) / 4000;
  endfunction
  function automatic int t_cyc(input int m);
    int v[5] = '{600, 383, 240, 180, 120};
    return v[m];
  endfunction
  function automatic int t_set(input int m);
    int v[5] = '{70, 50, 30, 30, 25};
    return v[m];
  endfunction
  function automatic int t_act(input int m);
    int v[5] = '{165, 125, 100, 80, 70};
    return v[m];
  endfunction
  function automatic int exp_s(input int m); return cdiv(t_set(m)); endfunction
  function automatic int exp_a(input int m); return cdiv(t_act(m)); endfunction
  function automatic int exp_r(input int m);
    int r;
    r = cdiv(t_cyc(m)) - exp_s(m) - exp_a(m);
    return (r > 1) ? r : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int m, input int lim);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = 3'(m); cfg_wait_limit = WLW'(lim);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Runs one cycle and measures phase lengths at falling edges.
  task automatic run(input bit wr, input logic [15:0] pat, input logic [1:0] cs,
                     input logic [2:0] da, input int rel,
                     output int s, output int a, output int r,
                     output bit addr_ok, output bit oe_ok, output bit once,
                     output bit e, output logic [15:0] rd);
    bit strobe_low, other_low;
    s = 0; a = 0; r = 0; addr_ok = 1; oe_ok = 1; once = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_write = wr; req_cs_n = cs; req_da = da; req_wdata = pat;
    ata_dd_in = pat; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    strobe_low = wr ? !ata_diow_n : !ata_dior_n;
    while (!strobe_low) begin
      s++;
      other_low = wr ? !ata_dior_n : !ata_diow_n;
      if (ata_cs_n != cs || ata_da != da || other_low) addr_ok = 0;
      if (wr ? (!ata_dd_oe || ata_dd_out != pat) : ata_dd_oe) oe_ok = 0;
      @(negedge clk);
      strobe_low = wr ? !ata_diow_n : !ata_dior_n;
    end
    while (strobe_low) begin
      a++;
      other_low = wr ? !ata_dior_n : !ata_diow_n;
      if (ata_cs_n != cs || ata_da != da || other_low) addr_ok = 0;
      if (wr ? (!ata_dd_oe || ata_dd_out != pat) : ata_dd_oe) oe_ok = 0;
      if (rel > 0 && a == rel) ata_iordy = 1'b1;
      @(negedge clk);
      strobe_low = wr ? !ata_diow_n : !ata_dior_n;
    end
    if (!wr) ata_dd_in = ~pat;
    while (!done) begin
      r++;
      if (ata_cs_n != cs || ata_da != da || !ata_dior_n || !ata_diow_n) addr_ok = 0;
      if (wr ? (!ata_dd_oe || ata_dd_out != pat) : ata_dd_oe) oe_ok = 0;
      @(negedge clk);
    end
    rd = rdata; e = err;
    if (ata_cs_n != 2'b11 || ata_da != 3'd0 || !req_ready) addr_ok = 0;
    @(negedge clk);
    if (done) once = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s, a, r;
    bit addr_ok, oe_ok, once, e;
    logic [15:0] rd, pat, last_rd;
    rst_n = 1'b0; cfg_wr = 0; cfg_mode = 0; cfg_wait_limit = '0;
    req_valid = 0; req_write = 0; req_cs_n = 2'b11; req_da = 0; req_wdata = 0;
    ata_dd_in = 0; ata_iordy = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(ata_dior_n && ata_diow_n && ata_cs_n == 2'b11 && ata_da == 0 &&
        !ata_dd_oe && !done && !err, "R1 reset outputs",
        {ata_dior_n, ata_diow_n, ata_cs_n, ata_dd_oe, done, err}, 7'b1111000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    // R1: default mode 0 timing
    run(1'b0, 16'h1234, 2'b10, 3'd7, 0, s, a, r, addr_ok, oe_ok, once, e, rd);
    chk(s == exp_s(0) && a == exp_a(0), "R1 reset mode 0 timing", s * 1000 + a,
        exp_s(0) * 1000 + exp_a(0));
    last_rd = rd;

    // Sweep all modes in both directions.
    for (int m = 0; m < 5; m++) begin
      for (int w = 0; w < 2; w++) begin
        set_cfg(m, 255);
        pat = 16'hA5C3 ^ (16'(m) * 16'h1111) ^ (w != 0 ? 16'h0F0F : 16'h0000);
        run(w != 0, pat, (m % 2 != 0) ? 2'b01 : 2'b10, 3'(m + w), 0,
            s, a, r, addr_ok, oe_ok, once, e, rd);
        chk(s == exp_s(m), $sformatf("R2 setup mode %0d wr %0d", m, w), s, exp_s(m));
        chk(addr_ok, $sformatf("R2 address hold mode %0d wr %0d", m, w), addr_ok, 1);
        chk(a == exp_a(m), $sformatf("R3 active mode %0d wr %0d", m, w), a, exp_a(m));
        chk(r == exp_r(m), $sformatf("R4 recovery mode %0d wr %0d", m, w), r, exp_r(m));
        chk(s + a + r >= cdiv(t_cyc(m)), $sformatf("R4 total mode %0d", m),
            s + a + r, cdiv(t_cyc(m)));
        chk(oe_ok, $sformatf("R5 data drive mode %0d wr %0d", m, w), oe_ok, 1);
        chk(once && !e, $sformatf("R7 done pulse mode %0d wr %0d", m, w), {once, e}, 2);
        if (w == 0) begin
          chk(rd == pat, $sformatf("R6 read capture mode %0d", m), rd, pat);
          last_rd = pat;
        end else begin
          chk(rd == last_rd, $sformatf("R6 rdata kept over write mode %0d", m), rd, last_rd);
        end
      end
    end

    // R8: slow mode ignores IORDY low
    set_cfg(1, 4);
    ata_iordy = 1'b0;
    run(1'b0, 16'h5A5A, 2'b10, 3'd2, 0, s, a, r, addr_ok, oe_ok, once, e, rd);
    chk(a == exp_a(1), "R8 mode 1 ignores iordy width", a, exp_a(1));
    chk(!e && rd == 16'h5A5A, "R8 mode 1 no error", e, 0);
    ata_iordy = 1'b1;

    // R9: fast mode stretches until IORDY returns
    set_cfg(3, 40);
    ata_iordy = 1'b0;
    run(1'b1, 16'hC0DE, 2'b01, 3'd5, 25, s, a, r, addr_ok, oe_ok, once, e, rd);
    chk(a > exp_a(3) && a <= exp_a(3) + 40 && a >= 25, "R9 mode 3 stretched width",
        a, 27);
    chk(!e && once && oe_ok, "R9 mode 3 normal completion", e, 0);
    ata_iordy = 1'b1;

    // R10: timeout abort in mode 4
    set_cfg(4, 6);
    ata_iordy = 1'b0;
    run(1'b0, 16'hBEEF, 2'b10, 3'd1, 0, s, a, r, addr_ok, oe_ok, once, e, rd);
    chk(a == exp_a(4) + 6, "R10 timeout width", a, exp_a(4) + 6);
    chk(e, "R10 error with done", e, 1);
    chk(r == exp_r(4) && once, "R10 recovery after abort", r, exp_r(4));
    ata_iordy = 1'b1;

    // R11: out-of-range mode acts as mode 4
    set_cfg(7, 255);
    run(1'b1, 16'h7777, 2'b10, 3'd3, 0, s, a, r, addr_ok, oe_ok, once, e, rd);
    chk(s == exp_s(4), "R11 clamp setup", s, exp_s(4));
    chk(a == exp_a(4), "R11 clamp active", a, exp_a(4));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule